// File: doc/BRIEF.md
# Scatter-Gather Bus-Master Disk DMA Engine

This block is the bus-master half of a disk interface. Software sets up a table of two-word descriptors in memory, writes the table's base address, the per-sector word count and the number of sectors, and then sets the start bit. The engine reads each descriptor through a single-outstanding request/grant memory read port. It then issues one 16-bit transfer strobe, with its memory address, for every cycle in which the device side asks for a word. An external datapath moves the word between memory and the device FIFO in the direction the command selects.

The engine counts down the bytes of the current descriptor. It fetches the next descriptor only once that count is spent. It also counts words into sectors, so that the end of the table can be compared with the end of the request. It finishes cleanly only when both run out together. Any mismatch, a memory read error or a descriptor whose region would cross a 64 KiB address boundary ends the run with the error flag set.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset the status byte reads 0x00, no memory request is raised and no transfer strobe is issued.
- R2: Writing register 0 with bit 0 set while idle sets status bit 0 (active). The engine reads the first descriptor word at the table pointer (register 2) and the second at pointer+4. Later descriptors follow at steps of 8 bytes, and each is fetched only after the previous one's byte count reaches zero. A memory request holds its address until it is granted.
- R3: Descriptor word 0 carries the byte count in bits 15:0 and the end-of-table mark in bit 31. Word 1 is the buffer address. A count of 0 stands for 65536 bytes.
- R4: While a descriptor has bytes left, each cycle with `dev_req` high yields one `xfer_stb`. The address starts at the buffer address and rises by 2 per strobe, and each strobe uses 2 bytes. `xfer_to_mem` equals bit 3 of the command written at start.
- R5: The words per sector come from register 3 when command bit 4 is 0 at start, and from register 4 when it is 1. The sector count is loaded from register 5. No strobe is issued once the sector count has run out.
- R6: When the end-of-table descriptor is spent and the sector count is zero, active clears and status bit 2 (interrupt) sets, with error left at 0.
- R7: If the table ends with sectors still left, or the sectors run out while table bytes remain, error (status bit 1) sets and active clears.
- R8: An error response on either descriptor word sets error, clears active and stops all further fetching.
- R9: A descriptor whose address plus count would pass a 64 KiB boundary sets error before any strobe. A region ending exactly on the boundary is legal.
- R10: Writing register 1 with 1 in bit 1 or bit 2 clears that flag, and writing 0 there leaves it unchanged. Bits 6:5 take the written value as drive-capable flags. Bit 0 cannot be written.
- R11: While the device holds `dev_req` low, active stays set indefinitely. Writing register 0 with bit 0 clear stops the engine: active clears, and neither interrupt nor error is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select (0 cmd, 1 status, 2 table pointer, 3/4 words per sector drive 0/1, 5 sector count) |
| reg_wdata | input | 32 | Register write data |
| status_o | output | 8 | Status byte: bit 0 active, 1 error, 2 interrupt, 6:5 drive-capable flags |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor read address |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| mem_rerr | input | 1 | Read error response, qualified by mem_rvalid |
| dev_req | input | 1 | Device side ready to move one word this cycle |
| xfer_stb | output | 1 | One 16-bit word moves this cycle |
| xfer_addr | output | 32 | Memory byte address of the word |
| xfer_to_mem | output | 1 | 1: device to memory, 0: memory to device |

## Verification
The assertions assume that the memory port returns exactly one response per granted request and never raises `mem_rvalid` unrequested. They also assume that the words-per-sector value is non-zero and that descriptor counts are even. The bench's memory responder grants one request at a time and answers it on the following cycle. Every test programs a non-zero sector size and even byte counts, including the 65536-byte case. Register writes are made only at the points the checks expect, such as a stop while active or a flag clear while idle.

// File: rtl/sg_dma_pkg.sv
// Shared types and constants for the scatter-gather disk DMA engine.
// Assumes a 3-bit register select and an 8-bit status byte.
package sg_dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_LO,
        ST_WAIT_LO,
        ST_REQ_HI,
        ST_WAIT_HI,
        ST_MOVE
    } dma_state_e;

    localparam logic [2:0] RA_CMD  = 3'd0;
    localparam logic [2:0] RA_STS  = 3'd1;
    localparam logic [2:0] RA_PTR  = 3'd2;
    localparam logic [2:0] RA_WPS0 = 3'd3;
    localparam logic [2:0] RA_WPS1 = 3'd4;
    localparam logic [2:0] RA_SECS = 3'd5;

    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 3;
    localparam int CMD_DRV = 4;

    localparam int STS_ACT = 0;
    localparam int STS_ERR = 1;
    localparam int STS_IRQ = 2;
endpackage

// File: rtl/sg_dma_regs.sv
// Register file of the DMA engine: command decode, status flags with
// write-one-to-clear, table pointer, per-drive sector sizes and sector count.
// Assumes set requests from the controller take priority over software clears.
module sg_dma_regs
    import sg_dma_pkg::*;
#(
    parameter int AW      = 32,
    parameter int WPS_W   = 16,
    parameter int SEC_W   = 16,
    parameter int WPS_RST = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [AW-1:0]    reg_wdata,
    input  logic             active_i,
    input  logic             set_err_i,
    input  logic             set_irq_i,
    output logic             launch_o,
    output logic             stop_o,
    output logic             dir_o,
    output logic [AW-1:0]    tbl_ptr_o,
    output logic [WPS_W-1:0] wps_o,
    output logic [SEC_W-1:0] secs_o,
    output logic [7:0]       status_o
);
    logic             cmd_wr, sts_wr;
    logic             dir_q, err_q, irq_q;
    logic [1:0]       cap_q;
    logic [WPS_W-1:0] wps0_q, wps1_q;

    // Decode command writes into launch and stop requests.
    always_comb begin
        cmd_wr   = reg_we && (reg_addr == RA_CMD);
        sts_wr   = reg_we && (reg_addr == RA_STS);
        launch_o = cmd_wr && reg_wdata[CMD_GO] && !active_i;
        stop_o   = cmd_wr && !reg_wdata[CMD_GO] && active_i;
        wps_o    = reg_wdata[CMD_DRV] ? wps1_q : wps0_q;
        dir_o    = dir_q;
        status_o = {1'b0, cap_q, 2'b00, irq_q, err_q, active_i};
    end

    // Configuration registers; direction only changes while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= 1'b0;
            tbl_ptr_o <= '0;
            wps0_q    <= WPS_W'(WPS_RST);
            wps1_q    <= WPS_W'(WPS_RST);
            secs_o    <= '0;
            cap_q     <= 2'b00;
        end else begin
            if (cmd_wr && !active_i) dir_q <= reg_wdata[CMD_DIR];
            if (reg_we && reg_addr == RA_PTR)  tbl_ptr_o <= reg_wdata;
            if (reg_we && reg_addr == RA_WPS0) wps0_q <= reg_wdata[WPS_W-1:0];
            if (reg_we && reg_addr == RA_WPS1) wps1_q <= reg_wdata[WPS_W-1:0];
            if (reg_we && reg_addr == RA_SECS) secs_o <= reg_wdata[SEC_W-1:0];
            if (sts_wr) cap_q <= reg_wdata[6:5];
        end
    end

    // Error and interrupt flags: hardware set wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (set_err_i) err_q <= 1'b1;
            else if (sts_wr && reg_wdata[STS_ERR]) err_q <= 1'b0;
            if (set_irq_i) irq_q <= 1'b1;
            else if (sts_wr && reg_wdata[STS_IRQ]) irq_q <= 1'b0;
        end
    end

    a_r10_irq_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr && reg_wdata[STS_IRQ] && !set_irq_i |=> !status_o[STS_IRQ]);
    a_r10_cap_flags: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr |=> status_o[6:5] == $past(reg_wdata[6:5]));
    a_r6_irq_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> !active_i);
endmodule

// File: rtl/sg_dma_sectors.sv
// Sector accounting: counts transferred words into sectors of a programmed
// size and reports when the requested number of sectors has been moved.
// Assumes a non-zero words-per-sector value is loaded at each launch.
module sg_dma_sectors #(
    parameter int WPS_W = 16,
    parameter int SEC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WPS_W-1:0] wps_i,
    input  logic [SEC_W-1:0] secs_i,
    input  logic             word_stb_i,
    output logic             sec_zero_o
);
    logic [WPS_W-1:0] wps_q, word_q;
    logic [SEC_W-1:0] left_q;

    // Load at launch, then advance the word and sector counts per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wps_q  <= '0;
            word_q <= '0;
            left_q <= '0;
        end else if (load_i) begin
            wps_q  <= wps_i;
            word_q <= '0;
            left_q <= secs_i;
        end else if (word_stb_i) begin
            if (word_q == wps_q - WPS_W'(1)) begin
                word_q <= '0;
                left_q <= left_q - SEC_W'(1);
            end else begin
                word_q <= word_q + WPS_W'(1);
            end
        end
    end

    // Zero-sector flag used by the controller for gating and completion.
    always_comb sec_zero_o = (left_q == '0);

    a_r5_no_word_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb_i |-> left_q != '0);
    a_r5_word_in_sector: assert property (@(posedge clk) disable iff (!rst_n)
        (wps_q != '0) |-> word_q < wps_q);
endmodule

// File: rtl/sg_dma_ctrl.sv
// Descriptor fetch and byte-count controller. Reads two-word descriptors one
// at a time, issues one word strobe per device request, and decides between
// clean completion and error at the end of the table or the request.
// Assumes one memory response per granted request and even byte counts.
module sg_dma_ctrl
    import sg_dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic          stop_i,
    input  logic [AW-1:0] tbl_ptr_i,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_rerr,
    input  logic          dev_req_i,
    input  logic          sec_zero_i,
    output logic          active_o,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          xfer_stb_o,
    output logic [AW-1:0] xfer_addr_o,
    output logic          set_err_o,
    output logic          set_irq_o
);
    localparam int BW = CNT_W + 1;
    localparam logic [BW-1:0]   FULL = {1'b1, {CNT_W{1'b0}}};
    localparam logic [BW-1:0]   TWO  = BW'(2);
    localparam logic [CNT_W+1:0] SPAN = {2'b01, {CNT_W{1'b0}}};

    dma_state_e    state_q;
    logic [AW-1:0] ptr_q;
    logic [BW-1:0] bytes_q;
    logic          eot_q;
    logic          desc_done, rd_err, crosses;
    logic [CNT_W+1:0] end_off;

    // Output decode and end-of-descriptor / error decisions.
    always_comb begin
        active_o    = (state_q != ST_IDLE);
        mem_req_o   = (state_q == ST_REQ_LO) || (state_q == ST_REQ_HI);
        mem_addr_o  = (state_q == ST_REQ_HI) ? ptr_q + AW'(4) : ptr_q;
        desc_done   = (state_q == ST_MOVE) && (bytes_q == '0);
        xfer_stb_o  = (state_q == ST_MOVE) && (bytes_q != '0) && !sec_zero_i && dev_req_i;
        end_off     = {2'b00, mem_rdata[CNT_W-1:0]} + {1'b0, bytes_q};
        crosses     = end_off > SPAN;
        rd_err      = ((state_q == ST_WAIT_LO) || (state_q == ST_WAIT_HI)) && mem_rvalid && mem_rerr;
        set_irq_o   = !stop_i && desc_done && eot_q && sec_zero_i;
        set_err_o   = !stop_i && (rd_err
                    || ((state_q == ST_WAIT_HI) && mem_rvalid && !mem_rerr && crosses)
                    || ((state_q == ST_MOVE) && (bytes_q != '0) && sec_zero_i)
                    || (desc_done && eot_q && !sec_zero_i));
    end

    // Sequencer: fetch word 0, fetch word 1, move bytes, repeat or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            ptr_q       <= '0;
            bytes_q     <= '0;
            eot_q       <= 1'b0;
            xfer_addr_o <= '0;
        end else if (stop_i) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (launch_i) begin
                    state_q <= ST_REQ_LO;
                    ptr_q   <= tbl_ptr_i;
                end
                ST_REQ_LO: if (mem_gnt) state_q <= ST_WAIT_LO;
                ST_WAIT_LO: if (mem_rvalid) begin
                    if (mem_rerr) state_q <= ST_IDLE;
                    else begin
                        bytes_q <= (mem_rdata[CNT_W-1:0] == '0) ? FULL
                                                                : {1'b0, mem_rdata[CNT_W-1:0]};
                        eot_q   <= mem_rdata[AW-1];
                        state_q <= ST_REQ_HI;
                    end
                end
                ST_REQ_HI: if (mem_gnt) state_q <= ST_WAIT_HI;
                ST_WAIT_HI: if (mem_rvalid) begin
                    if (mem_rerr || crosses) state_q <= ST_IDLE;
                    else begin
                        xfer_addr_o <= mem_rdata;
                        state_q     <= ST_MOVE;
                    end
                end
                ST_MOVE: begin
                    if (bytes_q == '0) begin
                        if (eot_q) state_q <= ST_IDLE;
                        else begin
                            ptr_q   <= ptr_q + AW'(8);
                            state_q <= ST_REQ_LO;
                        end
                    end else if (sec_zero_i) begin
                        state_q <= ST_IDLE;
                    end else if (dev_req_i) begin
                        xfer_addr_o <= xfer_addr_o + AW'(2);
                        bytes_q     <= (bytes_q >= TWO) ? bytes_q - TWO : '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_gnt && !stop_i |=> mem_req_o && $stable(mem_addr_o));
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb_o && (bytes_q > TWO) && !stop_i |=> xfer_addr_o == $past(xfer_addr_o) + AW'(2));
    a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MOVE) |-> bytes_q <= FULL);
    a_r8_err_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        set_err_o |=> !active_o);
    a_r2_no_fetch_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> !mem_req_o && !xfer_stb_o);
endmodule

// File: rtl/sg_dma_engine.sv
// Top of the scatter-gather disk DMA engine: wires the register file, the
// descriptor controller and the sector counter together.
// Assumes a single-outstanding descriptor read port and an external word mover.
module sg_dma_engine
    import sg_dma_pkg::*;
#(
    parameter int AW      = 32,
    parameter int CNT_W   = 16,
    parameter int WPS_W   = 16,
    parameter int SEC_W   = 16,
    parameter int WPS_RST = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [7:0]    status_o,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_rerr,
    input  logic          dev_req,
    output logic          xfer_stb,
    output logic [AW-1:0] xfer_addr,
    output logic          xfer_to_mem
);
    logic             launch, stop, active, set_err, set_irq, sec_zero;
    logic [AW-1:0]    tbl_ptr;
    logic [WPS_W-1:0] wps;
    logic [SEC_W-1:0] secs;

    sg_dma_regs #(.AW(AW), .WPS_W(WPS_W), .SEC_W(SEC_W), .WPS_RST(WPS_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .active_i(active), .set_err_i(set_err),
        .set_irq_i(set_irq), .launch_o(launch), .stop_o(stop), .dir_o(xfer_to_mem),
        .tbl_ptr_o(tbl_ptr), .wps_o(wps), .secs_o(secs), .status_o(status_o)
    );

    sg_dma_ctrl #(.AW(AW), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .launch_i(launch), .stop_i(stop),
        .tbl_ptr_i(tbl_ptr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .dev_req_i(dev_req),
        .sec_zero_i(sec_zero), .active_o(active), .mem_req_o(mem_req),
        .mem_addr_o(mem_addr), .xfer_stb_o(xfer_stb), .xfer_addr_o(xfer_addr),
        .set_err_o(set_err), .set_irq_o(set_irq)
    );

    sg_dma_sectors #(.WPS_W(WPS_W), .SEC_W(SEC_W)) u_sect (
        .clk(clk), .rst_n(rst_n), .load_i(launch), .wps_i(wps), .secs_i(secs),
        .word_stb_i(xfer_stb), .sec_zero_o(sec_zero)
    );

    a_r7_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_err && set_irq));
    a_r11_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !active && !$rose(status_o[STS_IRQ]));
endmodule

// File: tb/sg_dma_engine_test.sv
`timescale 1ns/1ps
module sg_dma_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  status_o;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_rerr = 1'b0;
    logic        dev_req = 1'b0;
    logic        xfer_stb;
    logic [31:0] xfer_addr;
    logic        xfer_to_mem;

    int n_chk = 0;
    int n_bad = 0;
    int n_stb = 0;
    bit done = 1'b0;
    bit chk_fetch = 1'b0;
    logic [31:0] exp_q[$];
    logic [31:0] fetch_q[$];
    logic [31:0] mem [0:15];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [31:0] paddr = '0;
    bit pend = 1'b0;

    always #2 clk = ~clk;

    sg_dma_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .status_o(status_o), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .dev_req(dev_req),
        .xfer_stb(xfer_stb), .xfer_addr(xfer_addr), .xfer_to_mem(xfer_to_mem)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory responder: grants one request, answers on the next cycle.
    always @(negedge clk) begin
        if (pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem[paddr[5:2]];
            mem_rerr   = (paddr == err_addr);
            pend       = 1'b0;
        end else begin
            mem_rvalid = 1'b0;
            mem_rerr   = 1'b0;
        end
        if (mem_req && !mem_gnt) begin
            mem_gnt = 1'b1;
            paddr   = mem_addr;
            pend    = 1'b1;
        end else begin
            mem_gnt = 1'b0;
        end
    end

    // Monitor: pops the scoreboard on every strobe and accepted fetch.
    always @(negedge clk) begin
        #1;
        if (rst_n && xfer_stb) begin
            n_stb++;
            if (exp_q.size() == 0) chk("R4 unexpected strobe", xfer_addr, 32'hxxxx_xxxx);
            else chk("R4 strobe address", xfer_addr, exp_q.pop_front());
        end
        if (rst_n && chk_fetch && mem_req && mem_gnt) begin
            if (fetch_q.size() == 0) chk("R2 unexpected fetch", mem_addr, 32'hxxxx_xxxx);
            else chk("R2 fetch address", mem_addr, fetch_q.pop_front());
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic desc(input int i, input logic [15:0] cnt, input bit eot, input logic [31:0] a);
        mem[2*i]   = {eot, 15'd0, cnt};
        mem[2*i+1] = a;
    endtask

    task automatic push_words(input logic [31:0] a, input int n);
        for (int k = 0; k < n; k++) exp_q.push_back(a + 32'(2*k));
    endtask

    task automatic wait_idle(input bit toggle);
        int t = 0;
        while (status_o[0] && t < 100000) begin
            @(negedge clk);
            if (toggle) dev_req = ~dev_req;
            t++;
        end
        dev_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] wps0, input logic [31:0] secs);
        n_stb = 0;
        wr(3'd2, 32'h100);
        wr(3'd3, wps0);
        wr(3'd5, secs);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status after reset", 32'(status_o), 32'h0);
        chk("R1 no request", 32'(mem_req), 32'h0);
        chk("R1 no strobe", 32'(xfer_stb), 32'h0);

        // R10 status flags and read-only active bit
        wr(3'd1, 32'h60);
        chk("R10 capable flags set", 32'(status_o), 32'h60);
        wr(3'd1, 32'h01);
        chk("R10 active not writable, flags cleared", 32'(status_o), 32'h00);

        // R2 R4 R5 R6 two descriptors, clean end
        setup(32'd2, 32'd3);
        desc(0, 16'd8, 1'b0, 32'h2000);
        desc(1, 16'd4, 1'b1, 32'h3000);
        push_words(32'h2000, 4);
        push_words(32'h3000, 2);
        fetch_q = '{32'h100, 32'h104, 32'h108, 32'h10C};
        chk_fetch = 1'b1;
        dev_req = 1'b1;
        wr(3'd0, 32'h1);
        chk("R2 active after start", 32'(status_o[0]), 32'h1);
        wait_idle(1'b0);
        chk_fetch = 1'b0;
        chk("R6 irq only", 32'(status_o), 32'h04);
        chk("R5 word count", 32'(n_stb), 32'd6);
        chk("R2 all fetches seen", 32'(fetch_q.size()), 32'd0);
        chk("R4 direction to device", 32'(xfer_to_mem), 32'h0);
        wr(3'd1, 32'h00);
        chk("R10 zero write keeps irq", 32'(status_o), 32'h04);
        wr(3'd1, 32'h04);
        chk("R10 irq cleared", 32'(status_o), 32'h00);

        // R4 R5 direction, drive 1 sector size, gapped device requests
        setup(32'd99, 32'd2);
        wr(3'd4, 32'd4);
        desc(0, 16'd16, 1'b1, 32'h4000);
        push_words(32'h4000, 8);
        wr(3'd0, 32'h19);
        chk("R4 direction to memory", 32'(xfer_to_mem), 32'h1);
        wait_idle(1'b1);
        chk("R5 drive 1 sizing completes", 32'(status_o), 32'h04);
        chk("R4 gapped word count", 32'(n_stb), 32'd8);
        wr(3'd1, 32'h04);

        // R3 zero count means 65536 bytes
        setup(32'd256, 32'd128);
        desc(0, 16'd0, 1'b1, 32'h0005_0000);
        push_words(32'h0005_0000, 32768);
        dev_req = 1'b1;
        wr(3'd0, 32'h1);
        wait_idle(1'b0);
        chk("R3 full 64KiB completes", 32'(status_o), 32'h04);
        chk("R3 full word count", 32'(n_stb), 32'd32768);
        wr(3'd1, 32'h04);

        // R9 region crossing 64 KiB
        setup(32'd2, 32'd8);
        desc(0, 16'h20, 1'b1, 32'h0001_FFF0);
        dev_req = 1'b1;
        wr(3'd0, 32'h1);
        wait_idle(1'b0);
        chk("R9 crossing sets error", 32'(status_o), 32'h02);
        chk("R9 no strobes", 32'(n_stb), 32'd0);
        wr(3'd1, 32'h02);
        chk("R10 error cleared", 32'(status_o), 32'h00);

        // R9 region ending exactly on the boundary
        setup(32'd8, 32'd1);
        desc(0, 16'h10, 1'b1, 32'h0001_FFF0);
        push_words(32'h0001_FFF0, 8);
        dev_req = 1'b1;
        wr(3'd0, 32'h1);
        wait_idle(1'b0);
        chk("R9 boundary end is legal", 32'(status_o), 32'h04);
        wr(3'd1, 32'h04);

        // R8 memory error on second descriptor word
        setup(32'd2, 32'd2);
        desc(0, 16'd8, 1'b1, 32'h6000);
        err_addr = 32'h104;
        dev_req = 1'b1;
        wr(3'd0, 32'h1);
        wait_idle(1'b0);
        err_addr = 32'hFFFF_FFFF;
        chk("R8 read error sets error", 32'(status_o), 32'h02);
        chk("R8 no strobes", 32'(n_stb), 32'd0);
        chk("R8 no further fetch", 32'(mem_req), 32'h0);
        wr(3'd1, 32'h02);

        // R7 table ends with sectors left
        setup(32'd2, 32'd3);
        desc(0, 16'd8, 1'b1, 32'h6000);
        push_words(32'h6000, 4);
        dev_req = 1'b1;
        wr(3'd0, 32'h1);
        wait_idle(1'b0);
        chk("R7 sectors left sets error", 32'(status_o), 32'h02);
        chk("R7 words before error", 32'(n_stb), 32'd4);
        wr(3'd1, 32'h02);

        // R7 sectors run out before the table
        setup(32'd2, 32'd1);
        desc(0, 16'd8, 1'b0, 32'h7000);
        desc(1, 16'd8, 1'b1, 32'h8000);
        push_words(32'h7000, 2);
        dev_req = 1'b1;
        wr(3'd0, 32'h1);
        wait_idle(1'b0);
        chk("R7 early sector end sets error", 32'(status_o), 32'h02);
        chk("R7 strobes stop with sectors", 32'(n_stb), 32'd2);
        wr(3'd1, 32'h02);

        // R11 device stall keeps active, stop clears it quietly
        setup(32'd2, 32'd2);
        desc(0, 16'd8, 1'b1, 32'h9000);
        dev_req = 1'b0;
        wr(3'd0, 32'h1);
        repeat (50) @(negedge clk);
        chk("R11 stalled stays active", 32'(status_o), 32'h01);
        chk("R11 no strobes while stalled", 32'(n_stb), 32'd0);
        wr(3'd0, 32'h0);
        chk("R11 stop without irq or error", 32'(status_o), 32'h00);
        chk("R11 no request after stop", 32'(mem_req), 32'h0);
        chk("R4 scoreboard drained", 32'(exp_q.size()), 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule